// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block takes a program arriving as a stream of bytes from a serial receiver and writes it into on-chip RAM, one byte per location, starting at address zero and counting upward. The stream carries no length field. Loading ends in one of two ways, whichever comes first:

- the byte for the top RAM address arrives, or
- the line stays quiet for four character times after the last byte.

When loading ends, the block emits a one-cycle completion pulse together with a jump address of zero, which tells the processor where to start the loaded code.

The receive side is a valid/ready stream. A byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. While loading, `rx_ready` stays high, so the block never stalls the sender. Once loading has ended, `rx_ready` stays low until reset. A sender that holds `rx_valid` high then keeps its byte, and that byte is never consumed.

Idle time is measured with a bit-time strobe `bit_tick`. One character time is ten ticks, so the quiet-line limit is forty ticks. The idle timer starts only when the first byte arrives, so a line that stays quiet before any byte never ends the load. While loading is in progress, `vec_in_ram` is high, which tells the interrupt logic to take its vectors from RAM.

Top module: `boot_loader`

## Requirements
- R1: After reset, `rx_ready` and `vec_in_ram` are 1, and `ram_we` and `load_done` are 0.
- R2: The n-th accepted byte (counting from 0) is written with `ram_addr` = n and `ram_wdata` equal to that byte.
- R3: `ram_we` is high for exactly one cycle per accepted byte, in the cycle after the handshake edge, and is never high otherwise.
- R4: Accepting the byte for address 511 ends the load. `load_done` is high in the same cycle as that byte's write, and `rx_ready` is low from then on.
- R5: Once at least one byte has arrived, the 40th `bit_tick` sampled after the last accepted byte ends the load. `load_done` is high in the cycle after that tick's edge.
- R6: Every accepted byte restarts the idle count. After 39 ticks, a new byte, and 39 more ticks, the load has not ended.
- R7: Before the first byte arrives, any number of ticks leaves the load running.
- R8: `load_done` is a single-cycle pulse that occurs once per load, and `jump_addr` is 0 whenever it is high.
- R9: After the load ends, `rx_ready` and `vec_in_ram` stay low, and bytes offered on the stream cause no write and no further `load_done`.
- R10: A byte and a tick arriving in the same cycle count as a restart. The tick is not counted, and 40 further ticks are needed to end the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts a byte; high while loading |
| rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| load_done | output | 1 | One-cycle end-of-load pulse |
| jump_addr | output | 16 | Start address of loaded code (always 0) |
| vec_in_ram | output | 1 | Interrupt vectors taken from RAM while high |

## Verification
The assertions assume the following about the inputs:

- `rx_valid` is held low while reset is applied.
- `bit_tick` is a one-cycle strobe.
- No more than 512 bytes are ever accepted, which follows from `rx_ready` falling at the top address.

The stimulus keeps within these assumptions:

- Inputs change only on the falling clock edge.
- Valid stays low across every reset.
- Ticks are issued one per cycle.

The bench still deliberately offers bytes after the load has ended, to show that they are refused.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic {
    LD_RUN  = 1'b0,
    LD_HALT = 1'b1
  } ld_state_t;
endpackage

// File: rtl/ld_idle_timer.sv
module ld_idle_timer #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic          armed;
  logic [CW-1:0] cnt;

  // A restart wins over a tick arriving in the same cycle.
  assign expire = enable && armed && tick && !restart && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && tick && cnt != CW'(LIMIT - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ld_write_seq.sv
module ld_write_seq #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              at_top
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] next_addr;

  assign at_top = accept && (next_addr == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we        <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      next_addr <= '0;
    end else begin
      we <= accept;
      if (accept) begin
        addr  <= next_addr;
        wdata <= din;
        if (next_addr != TOP) next_addr <= next_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int JUMP_W      = 16,
  parameter int TICKS_PER_CH = 10,
  parameter int IDLE_CHARS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              bit_tick,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              load_done,
  output logic [JUMP_W-1:0] jump_addr,
  output logic              vec_in_ram
);
  import loader_pkg::*;

  localparam int IDLE_TICKS = TICKS_PER_CH * IDLE_CHARS;

  ld_state_t state;
  logic      accept;
  logic      at_top;
  logic      expire;

  assign rx_ready   = (state == LD_RUN);
  assign vec_in_ram = (state == LD_RUN);
  assign accept     = rx_valid && rx_ready;
  assign jump_addr  = '0;

  ld_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .din    (rx_data),
    .we     (ram_we),
    .addr   (ram_addr),
    .wdata  (ram_wdata),
    .at_top (at_top)
  );

  ld_idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (rx_ready),
    .restart (accept),
    .tick    (bit_tick),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= LD_RUN;
      load_done <= 1'b0;
    end else begin
      load_done <= 1'b0;
      if (state == LD_RUN && (at_top || expire)) begin
        state     <= LD_HALT;
        load_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int ADDR_W = 9,
  parameter int JUMP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              load_done,
  input logic [JUMP_W-1:0] jump_addr,
  input logic              vec_in_ram
);
  logic [ADDR_W:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_cnt <= '0;
    else if (ram_we) wr_cnt <= wr_cnt + 1'b1;
  end

  p_we_from_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(rx_valid && rx_ready));

  p_addr_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == wr_cnt[ADDR_W-1:0]));

  p_top_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == {ADDR_W{1'b1}}) |-> load_done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_jump_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (jump_addr == '0));

  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> (!rx_ready && !ram_we && !load_done));

  p_vec_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !vec_in_ram);
endmodule

bind boot_loader boot_loader_chk #(.ADDR_W(ADDR_W), .JUMP_W(JUMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .load_done  (load_done),
  .jump_addr  (jump_addr),
  .vec_in_ram (vec_in_ram)
);

// File: tb/boot_loader_bench.sv
module boot_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        bit_tick = 1'b0;
  logic        ram_we;
  logic [8:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic        load_done;
  logic [15:0] jump_addr;
  logic        vec_in_ram;

  int checks = 0;
  int fails  = 0;
  int wr_seen = 0;
  int done_seen = 0;
  int sent_n = 0;
  logic [7:0] sent [DEPTH];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_loader u_boot_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .bit_tick(bit_tick), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .load_done(load_done), .jump_addr(jump_addr),
    .vec_in_ram(vec_in_ram)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Passive monitor: every write must land in order with the byte that was sent (R2, R3).
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      check(ram_addr == 9'(wr_seen), "R2 addr", ram_addr, wr_seen);
      check(wr_seen < sent_n && ram_wdata == sent[wr_seen], "R2 data", ram_wdata,
            (wr_seen < sent_n) ? sent[wr_seen] : -1);
      wr_seen++;
    end
    if (rst_n && load_done) begin
      check(jump_addr == 16'h0, "R8 jump", jump_addr, 0);
      done_seen++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_valid = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    wr_seen = 0; done_seen = 0; sent_n = 0;
    rst_n = 1'b1;
  endtask

  // Drive one byte for one cycle; call at a falling edge.
  task automatic send_byte(input logic [7:0] b, input bit with_tick = 0);
    sent[sent_n] = b; sent_n++;
    rx_valid = 1'b1; rx_data = b; bit_tick = with_tick;
    @(negedge clk);
    rx_valid = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(rx_ready == 1'b1, "R1 ready", rx_ready, 1);
    check(vec_in_ram == 1'b1, "R1 vec", vec_in_ram, 1);
    check(ram_we == 1'b0, "R1 we", ram_we, 0);
    check(load_done == 1'b0, "R1 done", load_done, 0);
  endtask

  task automatic t_idle_path();
    do_reset();
    ticks(100);
    check(done_seen == 0 && rx_ready, "R7 no end before first byte", done_seen, 0);
    send_byte(8'h3C); send_byte(8'hA5); send_byte(8'h00);
    @(negedge clk);
    check(wr_seen == 3, "R3 one write per byte", wr_seen, 3);
    ticks(39);
    send_byte(8'h7E);
    ticks(39);
    check(done_seen == 0 && load_done == 1'b0, "R6 restart on byte", done_seen, 0);
    ticks(1);
    check(load_done == 1'b1, "R5 idle end", load_done, 1);
    check(jump_addr == 16'h0, "R8 jump zero", jump_addr, 0);
    repeat (3) @(negedge clk);
    check(done_seen == 1, "R8 single pulse", done_seen, 1);
    check(rx_ready == 1'b0 && vec_in_ram == 1'b0, "R9 ready/vec low", rx_ready, 0);
    rx_valid = 1'b1; rx_data = 8'hEE;
    repeat (5) @(negedge clk);
    rx_valid = 1'b0;
    ticks(60);
    check(wr_seen == 4, "R9 no write after end", wr_seen, 4);
    check(done_seen == 1, "R9 no second done", done_seen, 1);
  endtask

  task automatic t_full();
    bit last_with_done = 0;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      sent[sent_n] = 8'((i * 7 + 3) & 8'hFF); sent_n++;
      rx_valid = 1'b1; rx_data = 8'((i * 7 + 3) & 8'hFF);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    last_with_done = (ram_we && ram_addr == 9'd511 && load_done);
    check(last_with_done, "R4 done with top write", int'(load_done), 1);
    check(rx_ready == 1'b0, "R4 ready low", rx_ready, 0);
    rx_valid = 1'b1; rx_data = 8'h11;
    repeat (4) @(negedge clk);
    rx_valid = 1'b0;
    check(wr_seen == DEPTH, "R4 write count", wr_seen, DEPTH);
    check(done_seen == 1, "R9 refused extra bytes", done_seen, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    send_byte(8'h5A);
    ticks(39);
    send_byte(8'hC3, 1);
    ticks(39);
    check(done_seen == 0 && load_done == 1'b0, "R10 tick with byte not counted", done_seen, 0);
    ticks(1);
    check(load_done == 1'b1, "R10 end after 40 more", load_done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_path();
    t_full();
    t_same_cycle();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule